// File: doc/BRIEF.md
# Stereo Sample Receive Queue

This block buffers left/right audio sample pairs between a serial audio receiver and a processor. Each strobe from the receiver carries one left word and one right word, which are stored together as a single entry. The processor takes data out with separate left and right read strobes. An entry is freed only after both of its halves have been read, and the two halves may be read in either order.

The queue holds eight pairs. If a pair arrives while the queue is full, it is thrown away and the stored data is left as it was. The block does not report the loss at once. It remembers the slot of the newest good entry and raises the overflow flag only when the reader reaches that slot. A read from an empty queue repeats the last value that was returned, leaves the read pointer where it is, and latches a sticky underflow flag.

Incoming words are right-justified to a selectable length of 16, 24 or 32 bits. The block also drives empty, half-full and full levels and one interrupt line. Each of the two error flags has its own enable for the interrupt.

Top module: `stereo_rx_fifo`

## Requirements
- R1: The queue stores at most 8 pairs, and each pair is written by a single `wr_pair` strobe.
- R2: The read pointer advances and the entry is freed only after both its left and its right half have been read, in either order. A half that is read again before release returns the same value.
- R3: A read while the queue is empty leaves `rd_data` at its previous value, does not move the read pointer, and sets `flag_unf`.
- R4: After reset, an empty read returns zero.
- R5: A pair written while the queue holds 8 pairs is discarded, and the 8 stored pairs read back unchanged.
- R6: After such a drop, `flag_ovf` stays low until the reader reaches the slot of the last accepted pair, which comes after 7 pairs have been freed. At that point it goes high.
- R7: `flag_ovf` goes low once both halves have been read from that marked slot.
- R8: `word_len` 0 keeps bits 15:0, 1 keeps bits 23:0, and 2 or 3 keeps all 32 bits. The bits above the kept ones read as zero.
- R9: `flag_empty` is high at 0 pairs, `flag_half` is high at 4 or fewer pairs, and `flag_full` is high at exactly 8 pairs.
- R10: `flag_unf` stays set until a `stat_rd` strobe or a reset.
- R11: `irq` = (`flag_ovf` and `irq_en_ovf`) or (`flag_unf` and `irq_en_unf`).
- R12: While `chan_en` is low, the occupancy, the pointers, the overflow marker and both error flags are cleared, and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable; low clears the queue state |
| word_len | input | 2 | Justification: 0=16, 1=24, 2/3=32 bits |
| wr_pair | input | 1 | Pair-valid strobe from the receiver |
| wr_left | input | 32 | Left sample in |
| wr_right | input | 32 | Right sample in |
| rd_left | input | 1 | Left half read strobe |
| rd_right | input | 1 | Right half read strobe |
| stat_rd | input | 1 | Status read strobe; clears underflow |
| irq_en_ovf | input | 1 | Overflow interrupt enable |
| irq_en_unf | input | 1 | Underflow interrupt enable |
| rd_data | output | 32 | Value returned by the last read, valid one cycle after the strobe |
| flag_empty | output | 1 | No pairs stored |
| flag_half | output | 1 | 4 or fewer pairs stored |
| flag_full | output | 1 | 8 pairs stored |
| flag_ovf | output | 1 | Deferred overflow indication |
| flag_unf | output | 1 | Sticky underflow |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the deferred overflow. The queue has to be filled, a ninth pair pushed, and then exactly seven pairs drained before the flag may appear. The directed overflow scenario does this with recognisable left/right values. It checks the flag after six and after seven drained pairs, and then checks that the eighth pair read out is the last accepted one and not the dropped one. The partial-read scenario reads the right half first and re-reads a half. This shows that the release condition does not depend on the order of the reads.

// File: rtl/srf_pkg.sv
package srf_pkg;
   typedef enum logic [1:0] {
      WL_16 = 2'd0,
      WL_24 = 2'd1,
      WL_32 = 2'd2,
      WL_32B = 2'd3
   } word_len_e;

   localparam int SHORT_W = 16;
   localparam int MID_W   = 24;
endpackage

// File: rtl/srf_justify.sv
module srf_justify
   import srf_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter bit JUSTIFY_EN = 1'b1
)(
   input  logic [1:0]        word_len,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   generate
      if (DATA_W < MID_W) begin : g_bad_width
         $error("srf_justify: DATA_W must be at least 24");
      end
      if (JUSTIFY_EN) begin : g_mask
         localparam logic [DATA_W-1:0] MASK16 = DATA_W'((64'd1 << SHORT_W) - 64'd1);
         localparam logic [DATA_W-1:0] MASK24 = DATA_W'((64'd1 << MID_W) - 64'd1);
         always_comb begin
            unique case (word_len_e'(word_len))
               WL_16:   dout = din & MASK16;
               WL_24:   dout = din & MASK24;
               default: dout = din;
            endcase
         end
      end else begin : g_pass
         logic [1:0] unused_wl;
         assign unused_wl = word_len;
         assign dout = din;
      end
   endgenerate
endmodule

// File: rtl/srf_store.sv
module srf_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8,
   localparam int PTR_W = $clog2(DEPTH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [PTR_W-1:0]  wp,
   input  logic [DATA_W-1:0] din_l,
   input  logic [DATA_W-1:0] din_r,
   input  logic              hit_l,
   input  logic              hit_r,
   input  logic [PTR_W-1:0]  rp,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem_l [DEPTH];
   logic [DATA_W-1:0] mem_r [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mem_l[i] <= '0;
            mem_r[i] <= '0;
         end else if (push && wp == PTR_W'(i)) begin
            mem_l[i] <= din_l;
            mem_r[i] <= din_r;
         end
      end
   end

   // Left wins if both halves are strobed together; an empty read keeps the value.
   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (hit_l) rd_data <= mem_l[rp];
      else if (hit_r) rd_data <= mem_r[rp];
   end
endmodule

// File: rtl/srf_ctrl.sv
module srf_ctrl #(
   parameter int DEPTH  = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic             wr_pair,
   input  logic             rd_left,
   input  logic             rd_right,
   input  logic             stat_rd,
   output logic             push,
   output logic             hit_l,
   output logic             hit_r,
   output logic [PTR_W-1:0] wp,
   output logic [PTR_W-1:0] rp,
   output logic [CNT_W-1:0] count,
   output logic             ovf_flag,
   output logic             unf_flag
);
   logic             got_l, got_r, release_e, is_empty, is_full, drop;
   logic             ovf_pend;
   logic [PTR_W-1:0] ovf_loc;

   assign is_empty  = (count == '0);
   assign is_full   = (count == CNT_W'(DEPTH));
   assign push      = wr_pair && chan_en && !is_full;
   assign drop      = wr_pair && chan_en && is_full;
   assign hit_l     = rd_left  && chan_en && !is_empty;
   assign hit_r     = rd_right && chan_en && !is_empty;
   assign release_e = (got_l || hit_l) && (got_r || hit_r);
   assign ovf_flag  = ovf_pend && (rp == ovf_loc);

   always_ff @(posedge clk) begin
      if (!rst_n || !chan_en) begin
         wp       <= '0;
         rp       <= '0;
         count    <= '0;
         got_l    <= 1'b0;
         got_r    <= 1'b0;
         ovf_pend <= 1'b0;
         ovf_loc  <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         count <= count + CNT_W'(push) - CNT_W'(release_e);
         if (release_e) begin
            rp    <= rp + 1'b1;
            got_l <= 1'b0;
            got_r <= 1'b0;
         end else begin
            got_l <= got_l || hit_l;
            got_r <= got_r || hit_r;
         end
         if (release_e && ovf_flag) begin
            ovf_pend <= 1'b0;
         end else if (drop && !ovf_pend) begin
            ovf_pend <= 1'b1;
            ovf_loc  <= wp - 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !chan_en)                             unf_flag <= 1'b0;
      else if (is_empty && (rd_left || rd_right))         unf_flag <= 1'b1;
      else if (stat_rd)                                   unf_flag <= 1'b0;
   end

   assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   assert_hold_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && !rd_left && !rd_right) |=> $stable(rp));
   assert_empty_read_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && is_empty && (rd_left || rd_right)) |=> $stable(rp));
   assert_empty_read_unf_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && is_empty && rd_left) |=> unf_flag);
   assert_drop_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pair && chan_en && is_full && !rd_left && !rd_right) |=> $stable(count));
   assert_marker_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_pend) |-> $past(wr_pair && is_full));
endmodule

// File: rtl/stereo_rx_fifo.sv
module stereo_rx_fifo #(
   parameter int DATA_W     = 32,
   parameter int DEPTH      = 8,
   parameter bit JUSTIFY_EN = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_en,
   input  logic [1:0]        word_len,
   input  logic              wr_pair,
   input  logic [DATA_W-1:0] wr_left,
   input  logic [DATA_W-1:0] wr_right,
   input  logic              rd_left,
   input  logic              rd_right,
   input  logic              stat_rd,
   input  logic              irq_en_ovf,
   input  logic              irq_en_unf,
   output logic [DATA_W-1:0] rd_data,
   output logic              flag_empty,
   output logic              flag_half,
   output logic              flag_full,
   output logic              flag_ovf,
   output logic              flag_unf,
   output logic              irq
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;
   localparam int HALF  = DEPTH / 2;

   generate
      if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
         $error("stereo_rx_fifo: DEPTH must be a power of two >= 2");
      end
   endgenerate

   logic              push, hit_l, hit_r;
   logic [PTR_W-1:0]  wp, rp;
   logic [CNT_W-1:0]  count;
   logic [DATA_W-1:0] jl, jr;

   srf_justify #(.DATA_W(DATA_W), .JUSTIFY_EN(JUSTIFY_EN)) u_just_l (
      .word_len(word_len), .din(wr_left), .dout(jl));
   srf_justify #(.DATA_W(DATA_W), .JUSTIFY_EN(JUSTIFY_EN)) u_just_r (
      .word_len(word_len), .din(wr_right), .dout(jr));

   srf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .wr_pair(wr_pair),
      .rd_left(rd_left), .rd_right(rd_right), .stat_rd(stat_rd),
      .push(push), .hit_l(hit_l), .hit_r(hit_r), .wp(wp), .rp(rp),
      .count(count), .ovf_flag(flag_ovf), .unf_flag(flag_unf));

   srf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .push(push), .wp(wp), .din_l(jl), .din_r(jr),
      .hit_l(hit_l), .hit_r(hit_r), .rp(rp), .rd_data(rd_data));

   assign flag_empty = (count == '0);
   assign flag_half  = (count <= CNT_W'(HALF));
   assign flag_full  = (count == CNT_W'(DEPTH));
   assign irq        = (flag_ovf && irq_en_ovf) || (flag_unf && irq_en_unf);

   assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag_ovf || flag_unf));
   assert_disable_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> (flag_empty && !flag_ovf && !flag_unf));
   assert_level_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flag_full |-> (!flag_half && !flag_empty));
endmodule

// File: tb/tb_stereo_rx_fifo.sv
module tb_stereo_rx_fifo;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chan_en = 1'b0;
   logic [1:0]  word_len = 2'd2;
   logic        wr_pair = 1'b0;
   logic [31:0] wr_left = '0, wr_right = '0;
   logic        rd_left = 1'b0, rd_right = 1'b0, stat_rd = 1'b0;
   logic        irq_en_ovf = 1'b0, irq_en_unf = 1'b0;
   logic [31:0] rd_data;
   logic        flag_empty, flag_half, flag_full, flag_ovf, flag_unf, irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   stereo_rx_fifo dut (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .word_len(word_len),
      .wr_pair(wr_pair), .wr_left(wr_left), .wr_right(wr_right),
      .rd_left(rd_left), .rd_right(rd_right), .stat_rd(stat_rd),
      .irq_en_ovf(irq_en_ovf), .irq_en_unf(irq_en_unf), .rd_data(rd_data),
      .flag_empty(flag_empty), .flag_half(flag_half), .flag_full(flag_full),
      .flag_ovf(flag_ovf), .flag_unf(flag_unf), .irq(irq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push(input logic [31:0] l, input logic [31:0] r);
      @(negedge clk);
      wr_pair = 1'b1; wr_left = l; wr_right = r;
      @(negedge clk);
      wr_pair = 1'b0;
   endtask

   task automatic rd(input bit left, output logic [31:0] v);
      @(negedge clk);
      if (left) rd_left = 1'b1; else rd_right = 1'b1;
      @(negedge clk);
      rd_left = 1'b0; rd_right = 1'b0;
      v = rd_data;
   endtask

   task automatic status_read();
      @(negedge clk); stat_rd = 1'b1;
      @(negedge clk); stat_rd = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R9 reset empty", 32'(flag_empty), 1);
      chk("R9 reset half", 32'(flag_half), 1);
      chk("R9 reset full", 32'(flag_full), 0);
      rd(1, v);
      chk("R4 first empty read zero", v, 0);
      chk("R3 underflow set", 32'(flag_unf), 1);
      status_read();
      chk("R10 underflow cleared by stat_rd", 32'(flag_unf), 0);
   endtask

   task automatic t_order();
      logic [31:0] v;
      push(32'h11, 32'h22);
      rd(0, v);
      chk("R2 right first value", v, 32'h22);
      chk("R2 not freed after one half", 32'(flag_empty), 0);
      rd(0, v);
      chk("R2 right re-read same", v, 32'h22);
      rd(1, v);
      chk("R2 left value", v, 32'h11);
      chk("R2 freed after both", 32'(flag_empty), 1);
   endtask

   task automatic t_justify();
      logic [31:0] v;
      word_len = 2'd0; push(32'hABCD1234, 32'h8765FEDC);
      word_len = 2'd1; push(32'hABCD1234, 32'h8765FEDC);
      word_len = 2'd3; push(32'hABCD1234, 32'h8765FEDC);
      word_len = 2'd2;
      rd(1, v); chk("R8 16-bit left", v, 32'h00001234);
      rd(0, v); chk("R8 16-bit right", v, 32'h0000FEDC);
      rd(1, v); chk("R8 24-bit left", v, 32'h00CD1234);
      rd(0, v); chk("R8 24-bit right", v, 32'h0065FEDC);
      rd(0, v); chk("R8 32-bit right", v, 32'h8765FEDC);
      rd(1, v); chk("R8 32-bit left", v, 32'hABCD1234);
      chk("R9 empty after drain", 32'(flag_empty), 1);
   endtask

   task automatic t_overflow();
      logic [31:0] v;
      irq_en_ovf = 1'b1;
      for (int i = 0; i < 8; i++) begin
         push(32'h100 + 32'(i), 32'h200 + 32'(i));
         if (i == 3) chk("R9 half at 4", 32'(flag_half), 1);
         if (i == 4) chk("R9 not half at 5", 32'(flag_half), 0);
      end
      chk("R1 full at 8", 32'(flag_full), 1);
      push(32'hDEAD, 32'hBEEF);
      chk("R5 still full after drop", 32'(flag_full), 1);
      chk("R6 overflow deferred", 32'(flag_ovf), 0);
      for (int i = 0; i < 7; i++) begin
         rd(1, v); chk("R5 stored left intact", v, 32'h100 + 32'(i));
         rd(0, v); chk("R5 stored right intact", v, 32'h200 + 32'(i));
         if (i == 5) chk("R6 no overflow after 6 drained", 32'(flag_ovf), 0);
      end
      chk("R6 overflow at marked slot", 32'(flag_ovf), 1);
      chk("R11 irq from overflow", 32'(irq), 1);
      rd(1, v); chk("R5 last good left", v, 32'h107);
      chk("R7 overflow held after one half", 32'(flag_ovf), 1);
      rd(0, v); chk("R5 last good right", v, 32'h207);
      chk("R7 overflow cleared", 32'(flag_ovf), 0);
      chk("R11 irq cleared", 32'(irq), 0);
      chk("R9 empty", 32'(flag_empty), 1);
   endtask

   task automatic t_underflow();
      logic [31:0] v;
      irq_en_unf = 1'b0;
      rd(1, v);
      chk("R3 empty read repeats last", v, 32'h207);
      chk("R3 underflow flag", 32'(flag_unf), 1);
      chk("R11 irq gated off", 32'(irq), 0);
      irq_en_unf = 1'b1;
      @(negedge clk);
      chk("R11 irq underflow enabled", 32'(irq), 1);
      push(32'h55, 32'h66);
      chk("R10 underflow sticky", 32'(flag_unf), 1);
      rd(1, v);
      chk("R3 pointer did not move", v, 32'h55);
      rd(0, v);
      status_read();
      chk("R10 cleared", 32'(flag_unf), 0);
      chk("R11 irq low", 32'(irq), 0);
   endtask

   task automatic t_disable();
      push(32'h1, 32'h2);
      push(32'h3, 32'h4);
      @(negedge clk); chan_en = 1'b0;
      @(negedge clk);
      chk("R12 disable empties", 32'(flag_empty), 1);
      push(32'h9, 32'h9);
      chk("R12 write ignored when disabled", 32'(flag_empty), 1);
      chan_en = 1'b1;
      @(negedge clk);
      chk("R12 still empty after enable", 32'(flag_empty), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1; chan_en = 1'b1;
      @(negedge clk);
      t_reset();
      t_order();
      t_justify();
      t_overflow();
      t_underflow();
      t_disable();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule